// File: doc/BRIEF.md
# Byte-Sliced Control/Status Register Bank

This block is a register file placed on an 8-bit bus. Each register is wider than the bus, so it is cut into byte slices. Each slice sits at its own 32-bit word address. The bus address carries two things: a bank number, which picks one fixed window of 2048 bytes, and a word index inside that window. Every bank has the same layout. Control registers come first, followed by status registers, and they are packed with no gaps between them.

Control registers can be read and written. Their full values drive the `ctrl_o` bus toward user logic. Status registers are read-only and take their values from `stat_i`.

A status value is captured when its most significant slice is read. The slices read after that come from the captured copy, so software that reads a wide status value from the top byte down always gets bytes from one consistent sample.

Top module: `csr_slice_bank`

## Requirements
- R1: Byte address bits [13:11] select the bank. Bank b covers addresses 0x800*b up to 0x800*b+0x7FF. Bits [10:2] give the word index, and bits [1:0] are ignored.
- R2: With the default parameters each bank is laid out as follows:
  - control register 0 at words 0-2;
  - control register 1 at words 3-5;
  - status register 0 at words 6-10.

  Each register begins on the word right after the previous register's last slice.
- R3: A register's lowest word holds its most significant byte, and each following word holds the next lower byte.
- R4: A write to a control slice changes only that byte of the register. The new value appears on `ctrl_o` one clock after the write cycle, and every other bit of `ctrl_o` is left unchanged.
- R5: Reading a control slice returns the byte that was last written to it.
- R6: Writes to status slices are ignored. They change neither status read data nor `ctrl_o`.
- R7: Reading a status register's most significant slice returns the live top byte of `stat_i` and captures the whole value. The other slices return bytes of the last captured value, even if `stat_i` has changed since.
- R8: The following reads return zero: a bank number of `NUM_BANKS` or above, and a word beyond the last register in the bank. Writes to these addresses change nothing.
- R9: Read data is valid on `dat_r_o` one clock after a read cycle (`stb_i`=1, `we_i`=0). In all other cycles `dat_r_o` is zero.
- R10: While `rst_ni` is low, all control registers, all captured status values and `dat_r_o` are zero.
- R11: Bits above the register width in a register's most significant slice read as zero, and writes to them are dropped. For example, writing 0xFF to the top slice of a 20-bit register stores 0x0F.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| stb_i | input | 1 | Bus cycle valid |
| we_i | input | 1 | 1 = write, 0 = read |
| adr_i | input | ADDR_W | Byte address |
| dat_w_i | input | 8 | Write data |
| dat_r_o | output | 8 | Read data, registered |
| ctrl_o | output | NUM_BANKS*NUM_CTRL*CTRL_W | All control registers, bank-major |
| stat_i | input | NUM_BANKS*NUM_STAT*STAT_W | All status inputs, bank-major |

## Verification
A read presented in one cycle produces `dat_r_o` one clock later. A write presented in one cycle changes `ctrl_o` one clock later. A status capture is taken at the same edge as the read of the most significant slice.

The bench applies inputs on the falling edge. Its behavioural model updates on the rising edge from those settled inputs. Both `dat_r_o` and `ctrl_o` are compared with the model at every following falling edge, so each result is checked in exactly the cycle it is due.

The directed checks read back one cycle after the access. They also change `stat_i` between slice reads, which shows whether the data came from the captured copy or from the live input.

// File: rtl/csr_slice_pkg.sv
package csr_slice_pkg;
  localparam int BYTE_W     = 8;
  localparam int WORD_SHIFT = 2;   // 32-bit word stride on a byte address
  localparam int WIN_LG     = 11;  // 0x800-byte bank window
  localparam int IDX_W      = WIN_LG - WORD_SHIFT;

  function automatic int slices_of(input int w);
    return (w + BYTE_W - 1) / BYTE_W;
  endfunction
endpackage

// File: rtl/csr_addr_dec.sv
module csr_addr_dec
  import csr_slice_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int NUM_BANKS = 2
) (
  input  logic [ADDR_W-1:0]    adr_i,
  output logic [NUM_BANKS-1:0] bank_sel_o,
  output logic [IDX_W-1:0]     word_o
);
  localparam int BSEL_W = ADDR_W - WIN_LG;

  logic [BSEL_W-1:0] bank_field;
  logic              unused_lo;

  assign bank_field = adr_i[ADDR_W-1:WIN_LG];
  assign word_o     = adr_i[WIN_LG-1:WORD_SHIFT];
  assign unused_lo  = ^adr_i[WORD_SHIFT-1:0];

  always_comb begin
    for (int b = 0; b < NUM_BANKS; b++)
      bank_sel_o[b] = (bank_field == BSEL_W'(b));
  end
endmodule

// File: rtl/csr_ctrl_slices.sv
module csr_ctrl_slices
  import csr_slice_pkg::*;
#(
  parameter int W    = 20,
  parameter int BASE = 0
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             we_i,
  input  logic [IDX_W-1:0] word_i,
  input  logic [7:0]       wdat_i,
  output logic [W-1:0]     q_o,
  output logic [7:0]       rdat_o,
  output logic             hit_o
);
  localparam int NS = slices_of(W);
  localparam int TOP_BITS = W - (NS - 1) * BYTE_W;
  localparam logic [7:0] TOP_MASK = 8'((1 << TOP_BITS) - 1);

  // slc_q[0] sits at the lowest word and holds the most significant byte
  logic [7:0]    slc_q [NS];
  logic [NS-1:0] slot_hit;
  logic [W-1:0]  wr_bits;

  always_comb begin
    for (int k = 0; k < NS; k++)
      slot_hit[k] = (word_i == IDX_W'(BASE + k));
  end
  assign hit_o = |slot_hit;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      for (int k = 0; k < NS; k++) slc_q[k] <= '0;
    end else if (sel_i && we_i) begin
      for (int k = 0; k < NS; k++)
        if (slot_hit[k]) slc_q[k] <= wdat_i & ((k == 0) ? TOP_MASK : 8'hff);
    end
  end

  always_comb begin
    rdat_o = '0;
    for (int k = 0; k < NS; k++)
      if (slot_hit[k]) rdat_o = rdat_o | slc_q[k];
  end

  always_comb begin
    for (int i = 0; i < W; i++) begin
      q_o[i]     = slc_q[NS-1-i/BYTE_W][i%BYTE_W];
      wr_bits[i] = slot_hit[NS-1-i/BYTE_W];
    end
  end

  // R4: a slice write leaves every other bit of the register alone
  p_wr_one_byte_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (sel_i && we_i && hit_o) |=> (((q_o ^ $past(q_o)) & ~$past(wr_bits)) == '0));

  // R8: no write to this register, no change at its outputs
  p_ctrl_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !(sel_i && we_i && hit_o) |=> $stable(q_o));
endmodule

// File: rtl/csr_stat_slices.sv
module csr_stat_slices
  import csr_slice_pkg::*;
#(
  parameter int W    = 40,
  parameter int BASE = 6
) (
  input  logic             clk_i,
  input  logic             rst_ni,
  input  logic             sel_i,
  input  logic             rd_i,
  input  logic [IDX_W-1:0] word_i,
  input  logic [W-1:0]     d_i,
  output logic [7:0]       rdat_o,
  output logic             hit_o
);
  localparam int NS = slices_of(W);
  localparam int PW = NS * BYTE_W;

  logic [W-1:0]  snap_q;
  logic [PW-1:0] live_x, snap_x;
  logic [NS-1:0] slot_hit;
  logic          snap_take;

  assign live_x = PW'(d_i);
  assign snap_x = PW'(snap_q);

  always_comb begin
    for (int k = 0; k < NS; k++)
      slot_hit[k] = (word_i == IDX_W'(BASE + k));
  end
  assign hit_o     = |slot_hit;
  assign snap_take = sel_i && rd_i && slot_hit[0];

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)        snap_q <= '0;
    else if (snap_take) snap_q <= d_i;
  end

  // top slice reads live so it matches what is being captured
  always_comb begin
    rdat_o = '0;
    for (int k = 0; k < NS; k++)
      if (slot_hit[k])
        rdat_o = rdat_o | ((k == 0) ? live_x[PW-BYTE_W +: BYTE_W]
                                    : snap_x[(NS-1-k)*BYTE_W +: BYTE_W]);
  end

  // R7: captured copy moves only on a read of the top slice
  p_snap_hold_r7: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !snap_take |=> $stable(snap_q));
endmodule

// File: rtl/csr_slice_bank.sv
module csr_slice_bank
  import csr_slice_pkg::*;
#(
  parameter int ADDR_W    = 14,
  parameter int NUM_BANKS = 2,
  parameter int NUM_CTRL  = 2,
  parameter int CTRL_W    = 20,
  parameter int NUM_STAT  = 1,
  parameter int STAT_W    = 40
) (
  input  logic                                 clk_i,
  input  logic                                 rst_ni,
  input  logic                                 stb_i,
  input  logic                                 we_i,
  input  logic [ADDR_W-1:0]                    adr_i,
  input  logic [7:0]                           dat_w_i,
  output logic [7:0]                           dat_r_o,
  output logic [NUM_BANKS*NUM_CTRL*CTRL_W-1:0] ctrl_o,
  input  logic [NUM_BANKS*NUM_STAT*STAT_W-1:0] stat_i
);
  localparam int NSC       = slices_of(CTRL_W);
  localparam int NSS       = slices_of(STAT_W);
  localparam int RPB       = NUM_CTRL + NUM_STAT;
  localparam int NREG      = NUM_BANKS * RPB;
  localparam int STAT_BASE = NUM_CTRL * NSC;
  localparam int USED_W    = STAT_BASE + NUM_STAT * NSS;

  initial begin
    assert (CTRL_W <= 64 && STAT_W <= 64 && USED_W <= (1 << IDX_W))
      else $error("csr_slice_bank: register too wide or bank window overflow");
  end

  logic [NUM_BANKS-1:0] bank_sel;
  logic [IDX_W-1:0]     word;
  logic [7:0]           rd_vec [NREG];
  logic [NREG-1:0]      hit_vec, live_hit;
  logic [7:0]           rd_mux;
  logic                 rd_req, any_hit;

  assign rd_req = stb_i && !we_i;

  csr_addr_dec #(.ADDR_W(ADDR_W), .NUM_BANKS(NUM_BANKS)) u_dec (
    .adr_i     (adr_i),
    .bank_sel_o(bank_sel),
    .word_o    (word)
  );

  for (genvar b = 0; b < NUM_BANKS; b++) begin : g_bank
    for (genvar r = 0; r < NUM_CTRL; r++) begin : g_ctrl
      csr_ctrl_slices #(.W(CTRL_W), .BASE(r * NSC)) u_ctrl (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .sel_i (stb_i && bank_sel[b]),
        .we_i  (we_i),
        .word_i(word),
        .wdat_i(dat_w_i),
        .q_o   (ctrl_o[(b*NUM_CTRL+r)*CTRL_W +: CTRL_W]),
        .rdat_o(rd_vec[b*RPB+r]),
        .hit_o (hit_vec[b*RPB+r])
      );
    end
    for (genvar s = 0; s < NUM_STAT; s++) begin : g_stat
      csr_stat_slices #(.W(STAT_W), .BASE(STAT_BASE + s * NSS)) u_stat (
        .clk_i (clk_i),
        .rst_ni(rst_ni),
        .sel_i (stb_i && bank_sel[b]),
        .rd_i  (rd_req),
        .word_i(word),
        .d_i   (stat_i[(b*NUM_STAT+s)*STAT_W +: STAT_W]),
        .rdat_o(rd_vec[b*RPB+NUM_CTRL+s]),
        .hit_o (hit_vec[b*RPB+NUM_CTRL+s])
      );
    end
  end

  always_comb begin
    rd_mux   = '0;
    live_hit = '0;
    for (int b = 0; b < NUM_BANKS; b++)
      for (int j = 0; j < RPB; j++)
        if (bank_sel[b]) begin
          rd_mux             = rd_mux | rd_vec[b*RPB+j];
          live_hit[b*RPB+j]  = hit_vec[b*RPB+j];
        end
    any_hit = |live_hit;
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) dat_r_o <= '0;
    else         dat_r_o <= rd_req ? rd_mux : '0;
  end

  // R2: packed registers never overlap
  p_one_target_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $onehot0(live_hit));

  // R8: unmapped reads come back as zero
  p_unmapped_zero_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (rd_req && !any_hit) |=> (dat_r_o == '0));

  // R9: nothing on the read bus without a read
  p_idle_zero_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    !stb_i |=> (dat_r_o == '0));
endmodule

// File: tb/csr_slice_bank_test.sv
`timescale 1ns/1ps
module csr_slice_bank_test;
  localparam int NB = 2, NC = 2, CW = 20, NS = 1, SW = 40;
  localparam int CSL = 3, SSL = 5;

  logic              clk = 1'b0, rst_n = 1'b0;
  logic              stb = 1'b0, we = 1'b0;
  logic [13:0]       adr = '0;
  logic [7:0]        dw = '0;
  logic [7:0]        dat_r;
  logic [NB*NC*CW-1:0] ctrl;
  logic [NB*NS*SW-1:0] stat = '0;

  int    n_chk = 0, n_err = 0;
  bit    done = 0;
  string cur_req = "R10";

  always #2.5 clk = ~clk;

  csr_slice_bank uut (
    .clk_i(clk), .rst_ni(rst_n), .stb_i(stb), .we_i(we), .adr_i(adr),
    .dat_w_i(dw), .dat_r_o(dat_r), .ctrl_o(ctrl), .stat_i(stat)
  );

  // behavioural reference
  logic [CW-1:0] m_ctrl [NB][NC];
  logic [SW-1:0] m_snap [NB][NS];
  logic [7:0]    e_dat;

  always @(posedge clk or negedge rst_n) begin : model
    int bk, wd, r, k, by;
    logic [63:0] t;
    if (!rst_n) begin
      e_dat = 0;
      for (int i = 0; i < NB; i++) begin
        for (int j = 0; j < NC; j++) m_ctrl[i][j] = 0;
        for (int j = 0; j < NS; j++) m_snap[i][j] = 0;
      end
    end else begin
      e_dat = 0;
      bk = int'(adr) / 2048;
      wd = (int'(adr) % 2048) / 4;
      if (stb && bk < NB) begin
        if (wd < NC*CSL) begin
          r = wd / CSL; k = wd % CSL; by = CSL-1-k;
          t = 64'(m_ctrl[bk][r]);
          if (we) begin
            t = (t & ~(64'hff << (8*by))) | (64'(dw) << (8*by));
            m_ctrl[bk][r] = t[CW-1:0];
          end else e_dat = 8'(t >> (8*by));
        end else if (wd < NC*CSL + NS*SSL && !we) begin
          r = (wd - NC*CSL) / SSL; k = (wd - NC*CSL) % SSL; by = SSL-1-k;
          if (k == 0) m_snap[bk][r] = stat[(bk*NS+r)*SW +: SW];
          e_dat = 8'(64'(m_snap[bk][r]) >> (8*by));
        end
      end
    end
  end

  function automatic logic [NB*NC*CW-1:0] exp_ctrl();
    logic [NB*NC*CW-1:0] v;
    for (int i = 0; i < NB; i++)
      for (int j = 0; j < NC; j++) v[(i*NC+j)*CW +: CW] = m_ctrl[i][j];
    return v;
  endfunction

  task automatic check(string tag, logic [79:0] act, logic [79:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_err++;
      $display("FAIL %s: actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // per-cycle comparison, away from the active edge
  always @(negedge clk) begin
    if (!done) begin
      check({cur_req, " dat_r_o"}, 80'(dat_r), 80'(e_dat));
      check({cur_req, " ctrl_o"}, 80'(ctrl), 80'(exp_ctrl()));
    end
  end

  task automatic drive(bit s, bit w, logic [13:0] a, logic [7:0] d);
    @(negedge clk); stb = s; we = w; adr = a; dw = d;
  endtask
  task automatic wr(logic [13:0] a, logic [7:0] d); drive(1, 1, a, d); endtask
  task automatic idle(); drive(0, 0, '0, '0); endtask
  task automatic rd_chk(logic [13:0] a, logic [7:0] e, string tag);
    drive(1, 0, a, '0);
    @(negedge clk); stb = 0;
    check(tag, 80'(dat_r), 80'(e));
  endtask

  initial begin : watchdog
    repeat (100000) @(posedge clk);
    n_err++; n_chk++;
    $display("FAIL watchdog: actual=timeout expected=finish");
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end

  initial begin : stim
    logic [79:0] hold;
    stat = {40'hA1_B2C3_D4E5, 40'h11_2233_4455};
    repeat (3) @(negedge clk);
    check("R10 ctrl reset", 80'(ctrl), 80'(0));
    check("R10 dat reset", 80'(dat_r), 80'(0));
    rst_n = 1;

    cur_req = "R1";
    wr(14'h000, 8'h12); wr(14'h005, 8'h34); wr(14'h00a, 8'h56); idle();
    check("R11 top slice masked", 80'(ctrl[19:0]), 80'(20'h23456));
    rd_chk(14'h000, 8'h02, "R11");
    rd_chk(14'h004, 8'h34, "R3");
    rd_chk(14'h00b, 8'h56, "R3");
    wr(14'h80c, 8'h0a); wr(14'h810, 8'hbc); wr(14'h817, 8'hde); idle();
    check("R1 bank1 reg1", 80'(ctrl[79:60]), 80'(20'hABCDE));

    cur_req = "R4";
    wr(14'h811, 8'h00); idle();
    check("R4 mid byte", 80'(ctrl[79:60]), 80'(20'hA00DE));
    check("R4 others", 80'(ctrl[19:0]), 80'(20'h23456));
    cur_req = "R5";
    rd_chk(14'h80c, 8'h0a, "R5");
    rd_chk(14'h814, 8'hde, "R5");

    cur_req = "R6";
    hold = 80'(ctrl);
    for (int w = 6; w < 11; w++) wr(14'(w*4), 8'hff);
    idle();
    check("R6 ctrl untouched", 80'(ctrl), hold);
    rd_chk(14'h018, 8'h11, "R6");
    cur_req = "R7";
    stat[39:0] = 40'h99_8877_6655;
    rd_chk(14'h01c, 8'h22, "R7 from snapshot");
    rd_chk(14'h028, 8'h55, "R7 from snapshot");
    rd_chk(14'h018, 8'h99, "R7 live msb");
    rd_chk(14'h020, 8'h77, "R7 new snapshot");
    rd_chk(14'h818, 8'ha1, "R7 bank1 msb");
    rd_chk(14'h824, 8'hd4, "R7 bank1");

    cur_req = "R8";
    hold = 80'(ctrl);
    rd_chk(14'h1000, 8'h00, "R8 bank2");
    rd_chk(14'h002c, 8'h00, "R8 word11");
    rd_chk(14'h07fc, 8'h00, "R8 word511");
    wr(14'h1000, 8'hff); wr(14'h002c, 8'hff); wr(14'h3804, 8'hff); idle();
    check("R8 ctrl untouched", 80'(ctrl), hold);

    cur_req = "R9";
    wr(14'h004, 8'h77); idle();
    check("R9 no data after write", 80'(dat_r), 80'(0));
    drive(1, 0, 14'h004, '0); idle();
    check("R9 one-cycle latency", 80'(dat_r), 80'(8'h77));
    idle();
    check("R9 idle zero", 80'(dat_r), 80'(0));

    cur_req = "R2";
    for (int i = 0; i < 3000; i++) begin
      if (i % 37 == 0) stat = {16'($urandom), 32'($urandom), 32'($urandom)};
      drive(bit'($urandom_range(0, 1)), bit'($urandom_range(0, 1)),
            14'($urandom_range(0, 2) * 2048 + $urandom_range(0, 13) * 4 + $urandom_range(0, 3)),
            8'($urandom));
    end
    idle(); idle();
    done = 1;
    $display("Result: errors=%0d of %0d checks", n_err, n_chk);
    $finish;
  end
endmodule